// File: doc/BRIEF.md
# Circulating Bit-Serial Accumulator

This block keeps a running two's-complement sum of serial words that arrive least significant bit first. It holds the sum in a ring of one-bit registers. The ring is as long as one serial word period, which is 2n+2 cycles for an n-bit operand. A single full adder sits at the head of the ring. In each cycle it adds three bits: the incoming serial bit, the ring bit that has just come round, and the carry kept from the previous cycle. The sum bit enters the tail of the ring, and the whole ring moves by one place.

A start strobe marks the least significant bit of each new word. On that cycle the carry from the previous word is dropped. A clear input empties the ring before the first word of a new evaluation. The block also drives a parallel view of the ring and a 10-bit result narrowed from it. The narrowed result is taken at a parameterized bit offset and saturates at the limits of its range. It is meant to be read when the ring is word-aligned, which the aligned output reports.

Top module: `circ_serial_acc`

## Requirements
- R1: After reset the ring holds zero, the narrowed result is zero and the aligned output is 1.
- R2: Take a word applied on `sin` over one full period of RING_LEN = 2*OPND_W+2 cycles, starting with `start` high, LSB first. One cycle after its last bit, `acc_word` equals the previous ring value plus that word, modulo 2^RING_LEN.
- R3: In a cycle with `start` high and `clr` low, the carry-in is zero. `sout` then equals `sin` XOR `acc_word[0]`, so no carry passes from one word into the next.
- R4: The cycle after `clr` is high, the ring, the carry and the phase are zero and `aligned` is 1, whatever `sin` and `start` were. `clr` has priority over `start`.
- R5: In every cycle `sout` is the sum bit for that cycle. The cycle after any cycle without `clr`, the ring has moved one place toward bit 0 and `sout` has entered at bit RING_LEN-1.
- R6: `acc_word[0]` is the ring head. Over a word, `sout` gives the new sum bits LSB first.
- R7: If the ring value shifted arithmetically right by NET_LSB (default 8) fits in 10 signed bits, `net` equals that value. Fractional bits are dropped toward minus infinity.
- R8: If the shifted value is above 511, `net` is 10'h1FF. If it is below -512, `net` is 10'h200. The sign of `net` always matches `acc_word[RING_LEN-1]`.
- R9: `aligned` is high exactly when a whole number of word periods have passed since the last `start` or `clr`. It is low on the RING_LEN-1 cycles inside a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties the ring, the carry and the phase |
| start | input | 1 | Marks the LSB cycle of an incoming word |
| sin | input | 1 | Serial operand bit, LSB first |
| sout | output | 1 | Sum bit produced this cycle |
| acc_word | output | 2*OPND_W+2 | Parallel view of the ring, bit 0 at the adder head |
| net | output | 10 | Narrowed, saturated result |
| aligned | output | 1 | Ring holds the sum with its LSB at bit 0 |

## Verification
If the stored carry is wrong, `sout` shows it in the cycle where the carry is consumed. At the latest, the parallel word is off one cycle after the end of that word. A carry left over from an overflowing word shows up in `sout` on the very next start cycle. A stuck or misrouted ring bit shows up in `acc_word` one cycle later, and again in `sout` one full period later when that bit comes back to the head. A phase counter that drifts shows up as `aligned` high inside a word. Saturation faults show up only when the word is aligned, in `net` against the value in the upper ring bits.

// File: rtl/csacc_pkg.sv
package csacc_pkg;

    localparam int NET_W = 10;

    typedef enum logic [1:0] {
        RING_SHIFT = 2'd0,
        RING_FIRST = 2'd1,
        RING_CLEAR = 2'd2
    } ring_op_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_res_t;

    function automatic fa_res_t fa_eval(input logic a, input logic b, input logic cin);
        fa_res_t r;
        r.sum  = a ^ b ^ cin;
        r.cout = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

    function automatic ring_op_e op_decode(input logic clr, input logic start);
        if (clr)
            return RING_CLEAR;
        if (start)
            return RING_FIRST;
        return RING_SHIFT;
    endfunction

endpackage

// File: rtl/csacc_ctrl.sv
module csacc_ctrl
    import csacc_pkg::*;
#(
    parameter int RING_LEN = 34
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     start,
    output ring_op_e op,
    output logic     aligned
);

    localparam int PH_W = $clog2(RING_LEN);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RING_LEN - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    logic [PH_W-1:0] phase_q;

    assign op = op_decode(clr, start);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            unique case (op)
                RING_CLEAR: phase_q <= '0;
                RING_FIRST: phase_q <= PH_ONE;
                default:    phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_ONE;
            endcase
        end
    end

    assign aligned = (phase_q == '0);

endmodule

// File: rtl/csacc_adder.sv
module csacc_adder
    import csacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ring_op_e op,
    input  logic     sin,
    input  logic     head,
    output logic     sum
);

    logic    carry_q;
    logic    cin;
    fa_res_t res;

    assign cin = (op == RING_FIRST) ? 1'b0 : carry_q;
    assign res = fa_eval(sin, head, cin);
    assign sum = res.sum;

    always_ff @(posedge clk) begin
        if (rst || op == RING_CLEAR)
            carry_q <= 1'b0;
        else
            carry_q <= res.cout;
    end

endmodule

// File: rtl/csacc_ring.sv
module csacc_ring
    import csacc_pkg::*;
#(
    parameter int RING_LEN = 34
) (
    input  logic                clk,
    input  logic                rst,
    input  ring_op_e            op,
    input  logic                sum_in,
    output logic [RING_LEN-1:0] word
);

    for (genvar i = 0; i < RING_LEN; i++) begin : g_cell
        logic next_bit;
        if (i == RING_LEN - 1) begin : g_tail
            assign next_bit = sum_in;
        end else begin : g_body
            assign next_bit = word[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst || op == RING_CLEAR)
                word[i] <= 1'b0;
            else
                word[i] <= next_bit;
        end
    end

endmodule

// File: rtl/csacc_net.sv
module csacc_net
    import csacc_pkg::*;
#(
    parameter int RING_LEN = 34,
    parameter int NET_LSB  = 8
) (
    input  logic [RING_LEN-1:0] word,
    output logic [NET_W-1:0]    net
);

    localparam int TOP_LO = NET_LSB + NET_W - 1;
    localparam logic [NET_W-1:0] SAT_POS = {1'b0, {(NET_W-1){1'b1}}};
    localparam logic [NET_W-1:0] SAT_NEG = {1'b1, {(NET_W-1){1'b0}}};

    logic fits;

    if (TOP_LO >= RING_LEN - 1) begin : g_no_sat
        assign fits = 1'b1;
    end else begin : g_sat
        logic [RING_LEN-1-TOP_LO:0] top;
        assign top  = word[RING_LEN-1:TOP_LO];
        assign fits = (&top) | ~(|top);
    end

    always_comb begin
        if (fits)
            net = word[NET_LSB +: NET_W];
        else if (word[RING_LEN-1])
            net = SAT_NEG;
        else
            net = SAT_POS;
    end

endmodule

// File: rtl/circ_serial_acc.sv
module circ_serial_acc
    import csacc_pkg::*;
#(
    parameter int OPND_W  = 16,
    parameter int NET_LSB = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  start,
    input  logic                  sin,
    output logic                  sout,
    output logic [2*OPND_W+1:0]   acc_word,
    output logic [NET_W-1:0]      net,
    output logic                  aligned
);

    localparam int RING_LEN = 2 * OPND_W + 2;

    ring_op_e op;
    logic     sum_bit;

    csacc_ctrl #(.RING_LEN(RING_LEN)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .start   (start),
        .op      (op),
        .aligned (aligned)
    );

    csacc_adder u_adder (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .sin  (sin),
        .head (acc_word[0]),
        .sum  (sum_bit)
    );

    csacc_ring #(.RING_LEN(RING_LEN)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .sum_in (sum_bit),
        .word   (acc_word)
    );

    csacc_net #(.RING_LEN(RING_LEN), .NET_LSB(NET_LSB)) u_net (
        .word (acc_word),
        .net  (net)
    );

    assign sout = sum_bit;

endmodule

// File: rtl/csacc_checker.sv
module csacc_checker
    import csacc_pkg::*;
#(
    parameter int OPND_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                clr,
    input logic                start,
    input logic                sin,
    input logic                sout,
    input logic [2*OPND_W+1:0] acc_word,
    input logic [NET_W-1:0]    net,
    input logic                aligned
);

    localparam int L = 2 * OPND_W + 2;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (acc_word == '0 && aligned)); // R1

    AST_FIRST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (start && !clr) |-> (sout == (sin ^ acc_word[0]))); // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_word == '0 && aligned && net == '0)); // R4

    AST_RING_ROTATES: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (acc_word == {$past(sout), $past(acc_word[L-1:1])})); // R5

    AST_NET_SIGN: assert property (@(posedge clk) disable iff (rst)
        net[NET_W-1] == acc_word[L-1]); // R8

    AST_ALIGN_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (aligned && !clr) |=> !aligned); // R9

endmodule

bind circ_serial_acc csacc_checker #(.OPND_W(OPND_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .start    (start),
    .sin      (sin),
    .sout     (sout),
    .acc_word (acc_word),
    .net      (net),
    .aligned  (aligned)
);

// File: tb/circ_serial_acc_tb.sv
module circ_serial_acc_tb_top;

    localparam int OPND_W  = 16;
    localparam int NET_LSB = 8;
    localparam int L       = 2 * OPND_W + 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         start = 1'b0;
    logic         sin = 1'b0;
    logic         sout;
    logic [L-1:0] acc_word;
    logic [9:0]   net;
    logic         aligned;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [L-1:0] model = '0;

    always #5 clk = ~clk;

    circ_serial_acc #(.OPND_W(OPND_W), .NET_LSB(NET_LSB)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .start(start), .sin(sin),
        .sout(sout), .acc_word(acc_word), .net(net), .aligned(aligned)
    );

    function automatic logic [9:0] exp_net(input logic [L-1:0] v);
        longint s;
        s = longint'($signed(v)) >>> NET_LSB;
        if (s > 511)  return 10'h1FF;
        if (s < -512) return 10'h200;
        return s[9:0];
    endfunction

    task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_word(input string tag);
        chk({tag, " R2 acc_word"}, acc_word, model);
        chk({tag, " R7/R8 net"}, L'(net), L'(exp_net(model)));
        chk({tag, " R9 aligned at boundary"}, L'(aligned), L'(1));
    endtask

    task automatic run_word(input logic [L-1:0] w);
        logic [L-1:0] s;
        s = model + w;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            clr = 1'b0;
            start = (i == 0);
            sin = w[i];
            #1;
            chk("R9 aligned phase", L'(aligned), L'(i == 0));
            if (i == 0)
                chk("R3 start bit without carry", L'(sout), L'(s[0]));
            else
                chk("R5/R6 serial sum bit", L'(sout), L'(s[i]));
        end
        model = s;
        @(posedge clk);
        #2;
        check_word("word");
    endtask

    task automatic do_clear(input logic st);
        @(negedge clk);
        clr = 1'b1;
        start = st;
        sin = 1'b1;
        @(posedge clk);
        #2;
        model = '0;
        chk("R4 clear empties ring", acc_word, '0);
        chk("R4 clear net", L'(net), '0);
        chk("R4 clear aligned", L'(aligned), L'(1));
    endtask

    task automatic load(input logic [L-1:0] v);
        do_clear(1'b1);
        run_word(v);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset ring", acc_word, '0);
        chk("R1 reset net", L'(net), '0);
        chk("R1 reset aligned", L'(aligned), L'(1));

        // R7 boundaries and truncation
        load(L'(511) << NET_LSB);
        load(-(L'(512) << NET_LSB));
        load((L'(3) << NET_LSB) | L'(8'h80));
        load('1);
        // R8 saturation both ways
        load(L'(512) << NET_LSB);
        load(-(L'(513) << NET_LSB));
        // R3: overflowing word leaves a carry that must not wrap
        load('1);
        run_word(L'(1));
        run_word(L'(5));
        // R4: clear mid-word, with start low
        @(negedge clk);
        start = 1'b1; sin = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do_clear(1'b0);
        run_word(L'(7));

        for (int k = 0; k < 160; k++) begin
            logic [L-1:0] w;
            if (k % 16 == 0)
                do_clear($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 2) == 0)
                w = {$urandom(), $urandom()};
            else
                w = L'($signed(14'($urandom())));
            run_word(w);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule